// File: doc/BRIEF.md
# Square-Wave Interval Counter Channel

This block is one channel of an interval timer fixed in its square-wave mode. Software writes an initial count N through a byte-wide write port. The count is either a single byte with an implied zero high byte, or a low byte followed by a high byte. The channel loads the count, counts it down, and toggles its output at the end of each half-period. It then reloads the same count and repeats without further writes. An odd count uses different decrement steps in the two halves. The high half is therefore one clock longer than the low half, and the full period stays exactly N clocks.

A level input acts as an enable. While it is low, counting is frozen and the output is forced high at once, with no clock needed. A low-to-high change on that input is a trigger: it restarts the sequence from the initial count, beginning with the high half. A count written while the channel is already running does not disturb the half-period in progress. It takes effect at the next half-period boundary, or on the clock after a trigger if a trigger comes first. A count of one is not supported and gives an undefined waveform.

Top module: `sqw_counter`

## Requirements
- R1: After reset, `out` is high. It stays high while no count has been written.
- R2: The first completed count is loaded on the clock edge after the edge that completes the write. `out` is high from that load onward.
- R3: For an even count N, `out` is high for N/2 clocks and low for N/2 clocks, repeating with automatic reload.
- R4: For an odd count N (N ≥ 3), `out` is high for (N+1)/2 clocks and low for (N-1)/2 clocks. The high half steps by 1 and then by 2; the low half steps by 3 and then by 2.
- R5: A written count of 0 means 2^16, giving a period of 65536 clocks.
- R6: While `gate` is low, the count is held and `out` is high. If `gate` falls while `out` is low, `out` goes high in the same cycle without a clock edge.
- R7: A rising `gate` that is sampled at a clock edge reloads the initial count on the following edge. The high half restarts from there.
- R8: A count completed while the channel runs leaves the current half-period unchanged. The new count is used from the next half-period boundary on.
- R9: If a trigger follows a mid-run count write, the new count is loaded on the clock after the trigger.
- R10: With `cfg_word` = 1, the first write supplies bits 7:0 and the second supplies bits 15:8. Only the second write completes a count, so a lone low-byte write leaves the waveform unchanged. With `cfg_word` = 0, each write is a full count with bits 15:8 equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 1 | 1: two-byte count (low byte, then high byte); 0: single low byte |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Count byte |
| gate | input | 1 | Enable level; a rising edge is a trigger |
| out | output | 1 | Square-wave output |

## Verification
The hardest cases to reach are a new count that arrives partway through a half-period, and a low-byte-only write in two-byte mode. Both change only internal state, which shows up later, if at all, as a change of period. The stimulus writes the new byte or bytes at a known clock index inside a running waveform. It then compares `out` cycle by cycle against the expected mixed waveform: the old half-period completes, and the new count follows only from the boundary (or from a trigger made by pulsing `gate`). The immediate forcing of `out` when `gate` falls is observed one time unit after `gate` changes, between clock edges, at a point where `out` was low.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef logic [1:0] step_t;

  // Decrement applied on one counting clock.
  // Even values always move by 2. Odd values move by 1 in the high half
  // and by 3 in the low half, which fixes the duty split for odd counts.
  function automatic step_t half_step(input logic cnt_odd, input logic high_half);
    if (!cnt_odd)      return 2'd2;
    else if (high_half) return 2'd1;
    else               return 2'd3;
  endfunction

endpackage

// File: rtl/sqw_load_port.sv
module sqw_load_port #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_word,
  input  logic               wr_en,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic [CNT_W-1:0]   init_cnt,
  output logic               done_q
);
  localparam int BYTE_W = CNT_W / 2;
  localparam int HI_W   = CNT_W - BYTE_W;

  logic              hi_next;
  logic [BYTE_W-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_next  <= 1'b0;
      lo_hold  <= '0;
      init_cnt <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_en) begin
        if (cfg_word) begin
          if (!hi_next) begin
            lo_hold <= wr_data;
            hi_next <= 1'b1;
          end else begin
            init_cnt <= {wr_data[HI_W-1:0], lo_hold};
            hi_next  <= 1'b0;
            done_q   <= 1'b1;
          end
        end else begin
          init_cnt <= {{HI_W{1'b0}}, wr_data};
          hi_next  <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  // R10: a single-byte write lands in the low bits with a zero high part
  p_byte_capture_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cfg_word) |=> (init_cnt == {{HI_W{1'b0}}, $past(wr_data)} && done_q));

  // R10: the first byte of a two-byte pair never completes a count
  p_low_only_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cfg_word && !hi_next) |=> (!done_q && $stable(init_cnt)));

endmodule

// File: rtl/sqw_gate_edge.sv
module sqw_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise_now,
  output logic trig_q
);
  logic gate_q;

  assign rise_now = gate & ~gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b1;
      trig_q <= 1'b0;
    end else begin
      gate_q <= gate;
      trig_q <= rise_now;
    end
  end

  // R7: a pending trigger lasts exactly one clock
  p_trig_single_r7: assert property (@(posedge clk) disable iff (rst)
    trig_q |=> !trig_q);

endmodule

// File: rtl/sqw_half_engine.sv
module sqw_half_engine
  import sqw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             rise_now,
  input  logic             trig_q,
  input  logic             done_q,
  input  logic [CNT_W-1:0] init_cnt,
  output logic             out_q
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] cnt;
  logic [EXT_W-1:0] init_ext;
  logic [EXT_W-1:0] step_ext;
  logic             running;
  logic             load_now;
  logic             advance;
  step_t            step;

  // A count of zero stands for 2^CNT_W
  assign init_ext = (init_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, init_cnt};
  assign step     = half_step(cnt[0], out_q);
  assign step_ext = {{(EXT_W-2){1'b0}}, step};
  assign load_now = (done_q && !running) || (trig_q && running);
  assign advance  = running && !load_now && gate && !rise_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      out_q   <= 1'b1;
      running <= 1'b0;
    end else if (load_now) begin
      cnt     <= init_ext;
      out_q   <= 1'b1;
      running <= 1'b1;
    end else if (running && !gate) begin
      out_q <= 1'b1;
    end else if (advance) begin
      if (cnt <= step_ext) begin
        cnt   <= init_ext;
        out_q <= ~out_q;
      end else begin
        cnt <= cnt - step_ext;
      end
    end
  end

  // R2 / R7: every load restarts the high half with the programmed count
  p_load_high_r7: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (out_q && cnt == $past(init_ext)));

  // R6: a low gate freezes the count
  p_hold_gate_low_r6: assert property (@(posedge clk) disable iff (rst)
    (running && !gate && !load_now) |=> $stable(cnt));

  // R4: odd value in the high half steps by one
  p_odd_high_step_r4: assert property (@(posedge clk) disable iff (rst)
    (advance && out_q && cnt[0] && cnt > 1) |=> (cnt == $past(cnt) - 1));

  // R4: odd value in the low half steps by three
  p_odd_low_step_r4: assert property (@(posedge clk) disable iff (rst)
    (advance && !out_q && cnt[0] && cnt > 3) |=> (cnt == $past(cnt) - 3));

  // R1: nothing counts before the first count arrives
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !running |-> out_q);

endmodule

// File: rtl/sqw_counter.sv
module sqw_counter #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_word,
  input  logic               wr_en,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               gate,
  output logic               out
);
  logic [CNT_W-1:0] init_cnt;
  logic             done_q;
  logic             rise_now;
  logic             trig_q;
  logic             out_q;

  sqw_load_port #(.CNT_W(CNT_W)) u_load (
    .clk      (clk),
    .rst      (rst),
    .cfg_word (cfg_word),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .init_cnt (init_cnt),
    .done_q   (done_q)
  );

  sqw_gate_edge u_gate (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate),
    .rise_now (rise_now),
    .trig_q   (trig_q)
  );

  sqw_half_engine #(.CNT_W(CNT_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate),
    .rise_now (rise_now),
    .trig_q   (trig_q),
    .done_q   (done_q),
    .init_cnt (init_cnt),
    .out_q    (out_q)
  );

  // Registered level, overridden high by a low gate without a clock (R6)
  assign out = out_q | ~gate;

  // R6: a low gate always shows a high output
  p_gate_low_out_high_r6: assert property (@(posedge clk) disable iff (rst)
    !gate |-> out);

endmodule

// File: tb/sim_sqw_counter.sv
module sim_sqw_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_word = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       gate = 1'b1;
  logic       out;

  int checks = 0;
  int fails  = 0;
  int idx    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sqw_counter u0 (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .wr_en(wr_en),
    .wr_data(wr_data), .gate(gate), .out(out)
  );

  function automatic logic exp_level(int n, int i);
    int nn = (n == 0) ? 65536 : n;
    int h  = (nn + 1) / 2;
    return ((i - 1) % nn) < h;
  endfunction

  task automatic tick();
    @(negedge clk);
    idx++;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; gate = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    wr_data = b; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic start_byte(input logic [7:0] n);
    put_byte(n);
    idx = 0;
  endtask

  task automatic start_word(input logic [15:0] n);
    put_byte(n[7:0]);
    put_byte(n[15:8]);
    idx = 0;
  endtask

  task automatic check1(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: out=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic check_wave(input int n, input int cycles, input string tag);
    int bad = 0;
    for (int k = 0; k < cycles; k++) begin
      tick();
      if (out !== exp_level(n, idx)) begin
        if (bad == 0)
          $display("FAIL %s: cycle %0d out=%0b expected=%0b", tag, idx, out, exp_level(n, idx));
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic t_reset_idle();
    do_reset();
    check1(out, 1'b1, "R1 reset level");
    repeat (10) tick();
    check1(out, 1'b1, "R1 idle without count");
  endtask

  task automatic t_even();
    do_reset(); cfg_word = 1'b0;
    start_byte(8'd4);
    check_wave(4, 16, "R2 R3 even count 4");
    do_reset();
    start_byte(8'd2);
    check_wave(2, 10, "R3 even count 2");
  endtask

  task automatic t_odd();
    do_reset(); cfg_word = 1'b0;
    start_byte(8'd5);
    check_wave(5, 20, "R4 odd count 5");
    do_reset();
    start_byte(8'd3);
    check_wave(3, 12, "R4 odd count 3");
  endtask

  task automatic t_word();
    do_reset(); cfg_word = 1'b1;
    start_word(16'd259);
    check_wave(259, 600, "R10 two-byte count 259");
  endtask

  task automatic t_zero();
    do_reset(); cfg_word = 1'b1;
    start_word(16'd0);
    check_wave(0, 65540, "R5 count 0 as 65536");
  endtask

  task automatic t_gate();
    do_reset(); cfg_word = 1'b0;
    start_byte(8'd6);
    check_wave(6, 4, "R4 count 6 before gate");
    check1(out, 1'b0, "R6 low half before gate drop");
    gate = 1'b0;
    #1;
    check1(out, 1'b1, "R6 immediate high on gate fall");
    tick();
    check1(out, 1'b1, "R6 held high while gate low");
    tick();
    gate = 1'b1;
    tick();
    idx = 0;
    check_wave(6, 12, "R7 restart after gate rise");
  endtask

  task automatic t_deferred();
    int bad = 0;
    do_reset(); cfg_word = 1'b0;
    start_byte(8'd8);
    check_wave(8, 2, "R8 count 8 lead-in");
    put_byte(8'd4);
    for (int k = 0; k < 11; k++) begin
      logic e;
      tick();
      e = (idx <= 4) ? 1'b1 : (((idx - 5) % 4) >= 2);
      if (out !== e) begin
        if (bad == 0) $display("FAIL R8 deferred count: cycle %0d out=%0b expected=%0b", idx, out, e);
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic t_trigger_new();
    do_reset(); cfg_word = 1'b0;
    start_byte(8'd8);
    check_wave(8, 2, "R9 count 8 lead-in");
    put_byte(8'd4);
    gate = 1'b0;
    tick();
    check1(out, 1'b1, "R9 gate low high level");
    gate = 1'b1;
    tick();
    idx = 0;
    check_wave(4, 12, "R9 new count after trigger");
  endtask

  task automatic t_low_only();
    int bad = 0;
    do_reset(); cfg_word = 1'b1;
    start_word(16'd6);
    check_wave(6, 12, "R10 word count 6");
    put_byte(8'h02);
    check_wave(6, 12, "R10 low byte alone ignored");
    put_byte(8'h00);
    for (int k = 0; k < 8; k++) begin
      logic e;
      tick();
      e = (idx <= 27) ? 1'b1 : (((idx - 28) % 2) != 0);
      if (out !== e) begin
        if (bad == 0) $display("FAIL R10 completed pair: cycle %0d out=%0b expected=%0b", idx, out, e);
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    t_reset_idle();
    t_even();
    t_odd();
    t_word();
    t_gate();
    t_deferred();
    t_trigger_new();
    t_low_only();
    t_zero();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule